// File: doc/BRIEF.md
# Narrow-Write Replicating Bus Bridge

This bridge takes single read or write requests from a system-side port and runs each one as one transfer on a simple 32-bit peripheral bus. That bus has a one-cycle setup phase followed by an access phase, which lasts until the peripheral signals ready. A request may be a byte, a half-word or a word. Narrow write data always arrives in the low bits of the upstream data word. The upper address bits pick one of several fixed windows, and each window has one of three kinds of target behind it. A lane-capable target takes narrow writes as byte strobes on the addressed lanes. A strict word target refuses anything narrower than a word. A lenient word target turns a narrow write into a full-word write: the narrow value is copied into every lane and the address is rounded down to the word.

The requester sets `req_valid` and holds all request fields steady until `resp_done` pulses for one cycle. On that pulse, `resp_err` and `resp_rdata` are valid. Only one request is in flight at a time. A request that the bridge refuses ends with an error one cycle after it is accepted, and nothing moves on the peripheral bus.

Top module: `lane_repl_bridge`

## Requirements
- R1: In a lenient word window, a byte write of value V at byte offset 0, 1, 2 or 3 goes downstream as address bits [1:0] = 00, data {V,V,V,V} and all four strobes set.
- R2: In a lenient word window, a half-word write of value H at offset 0 or 2 goes downstream as a word write of {H,H} to the word-aligned address with all four strobes set.
- R3: In a strict word window, every byte or half-word request, whether read or write, ends with `resp_err` = 1 and starts no downstream transfer.
- R4: In a lane-capable window, each write drives `per_strb` bit k for lane k, holding byte k in data bits [8k+7:8k]. A byte write sets only the bit of its offset. A half-word sets bits {1,0} at offset 0 or bits {3,2} at offset 2. Only those lanes of the target word change, and data bits above the request size are ignored.
- R5: Size code 2'b11 is illegal and ends with an error and no downstream transfer. The legal codes are 2'b00 byte, 2'b01 half-word and 2'b10 word.
- R6: In every window, a half-word at an odd address, or a word whose address bits [1:0] are not 00, ends with an error and no downstream transfer.
- R7: An accepted transfer spends exactly one cycle with `per_sel`=1 and `per_en`=0, then holds `per_sel`=`per_en`=1 with a stable address until `per_ready`. `resp_done` pulses in the cycle after ready. The whole request therefore takes 3 + (wait cycles) clocks, and a refused request takes 1.
- R8: If `per_err` is high in the cycle that completes the access, the upstream response for that request has `resp_err` = 1.
- R9: A read of any allowed size returns the full 32-bit word. The read uses the word-aligned address and drives `per_strb` = 0.
- R10: While in reset, `per_sel`, `per_en` and `resp_done` are low.
- R11: A word write in any window passes through unchanged with all four strobes set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until resp_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 illegal |
| req_wdata | input | 32 | Write data, narrow values in the low bits |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Error response, valid with resp_done |
| resp_rdata | output | 32 | Read word, valid with resp_done |
| per_sel | output | 1 | Peripheral select (setup and access) |
| per_en | output | 1 | Access phase enable |
| per_write | output | 1 | Peripheral write direction |
| per_addr | output | AW | Word-aligned peripheral address |
| per_wdata | output | 32 | Peripheral write data |
| per_strb | output | 4 | Byte-lane write strobes |
| per_rdata | input | 32 | Peripheral read data |
| per_ready | input | 1 | Peripheral completes the access |
| per_err | input | 1 | Peripheral error on completion |

## Verification
The bench sends the same byte and half-word patterns to all three window kinds. In the lane-capable window a narrow write changes only its own lane. In the lenient window the same write fills the whole word. In the strict window it is refused, and the downstream transfer count stays the same. Offsets 1 and 3 for bytes, and 2 for half-words, show whether the bridge picks lanes by offset or only aligns the address. A byte write with junk in the upper data bits shows whether those bits leak into the target. Requests with wait states, a peripheral error, the illegal size code and misaligned addresses check the phase timing and show which refusals start no transfer.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    KIND_LANE   = 2'b00,
    KIND_STRICT = 2'b01,
    KIND_REPL   = 2'b10,
    KIND_RSVD   = 2'b11
  } kind_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_BAD  = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SETUP  = 2'b01,
    ST_ACCESS = 2'b10
  } phase_e;
endpackage

// File: rtl/bridge_rst_sync.sv
module bridge_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bridge_win_decode.sv
module bridge_win_decode
  import bridge_pkg::*;
#(
  parameter int AW      = 16,
  parameter int SEL_LSB = 12,
  parameter int SEL_W   = 2,
  parameter logic [2*(1<<SEL_W)-1:0] WIN_KIND = 8'b01_10_01_00
) (
  input  logic [AW-1:0] addr,
  output kind_e         kind
);
  localparam int NWIN = 1 << SEL_W;

  kind_e               tbl [NWIN];
  logic [SEL_W-1:0]    win;

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      assign tbl[w] = kind_e'(WIN_KIND[2*w +: 2]);
    end
  endgenerate

  assign win  = addr[SEL_LSB +: SEL_W];
  assign kind = tbl[win];
endmodule

// File: rtl/bridge_lane_shaper.sv
module bridge_lane_shaper
  import bridge_pkg::*;
(
  input  kind_e       kind,
  input  logic        write,
  input  logic [1:0]  size,
  input  logic [1:0]  off,
  input  logic [31:0] din,
  output logic [31:0] dout,
  output logic [3:0]  strb,
  output logic        reject
);
  logic [3:0] hit;
  logic       narrow;
  logic       misal;
  logic       badsz;
  logic       narrow_ok;

  generate
    for (genvar i = 0; i < 4; i++) begin : g_lane
      assign dout[8*i +: 8] = (size == SZ_BYTE) ? din[7:0] :
                              (size == SZ_HALF) ? din[8*(i%2) +: 8] :
                                                  din[8*i +: 8];
      assign hit[i] = (size == SZ_BYTE) ? (off == 2'(i)) :
                      (size == SZ_HALF) ? (off[1] == 1'(i/2)) :
                                          1'b1;
    end
  endgenerate

  always_comb begin
    badsz     = (size == SZ_BAD);
    narrow    = (size != SZ_WORD);
    misal     = ((size == SZ_HALF) && off[0]) ||
                ((size == SZ_WORD) && (off != 2'b00));
    narrow_ok = (kind == KIND_LANE) || (kind == KIND_REPL);
    reject    = badsz || misal || (narrow && !narrow_ok);
    if (!write)                 strb = 4'b0000;
    else if (kind == KIND_LANE) strb = hit;
    else                        strb = 4'b1111;
  end
endmodule

// File: rtl/bridge_xfer_ctrl.sv
module bridge_xfer_ctrl
  import bridge_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_reject,
  input  logic [AW-1:0] req_addr_al,
  input  logic [31:0]   req_data,
  input  logic [3:0]    req_strb,
  input  logic          per_ready,
  input  logic          per_err,
  input  logic [31:0]   per_rdata,
  output logic          per_sel,
  output logic          per_en,
  output logic          per_write,
  output logic [AW-1:0] per_addr,
  output logic [31:0]   per_wdata,
  output logic [3:0]    per_strb,
  output logic          resp_done,
  output logic          resp_err,
  output logic [31:0]   resp_rdata
);
  phase_e        st_q, st_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [31:0]   rd_q, rd_d;
  logic          cap_en;
  logic [AW-1:0] addr_q;
  logic [31:0]   wd_q;
  logic [3:0]    strb_q;
  logic          wr_q;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    err_d  = err_q;
    rd_d   = rd_q;
    cap_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid && !done_q) begin
          if (req_reject) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            rd_d   = '0;
          end else begin
            cap_en = 1'b1;
            st_d   = ST_SETUP;
          end
        end
      end
      ST_SETUP:  st_d = ST_ACCESS;
      ST_ACCESS: begin
        if (per_ready) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          err_d  = per_err;
          rd_d   = wr_q ? '0 : per_rdata;
        end
      end
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= req_addr_al;
      wd_q   <= req_data;
      strb_q <= req_strb;
      wr_q   <= req_write;
    end
  end

  assign per_sel    = (st_q != ST_IDLE);
  assign per_en     = (st_q == ST_ACCESS);
  assign per_write  = wr_q;
  assign per_addr   = addr_q;
  assign per_wdata  = wd_q;
  assign per_strb   = strb_q;
  assign resp_done  = done_q;
  assign resp_err   = err_q;
  assign resp_rdata = rd_q;
endmodule

// File: rtl/lane_repl_bridge.sv
module lane_repl_bridge
  import bridge_pkg::*;
#(
  parameter int AW      = 16,
  parameter int SEL_LSB = 12,
  parameter int SEL_W   = 2,
  parameter logic [2*(1<<SEL_W)-1:0] WIN_KIND = 8'b01_10_01_00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  output logic          resp_done,
  output logic          resp_err,
  output logic [31:0]   resp_rdata,
  output logic          per_sel,
  output logic          per_en,
  output logic          per_write,
  output logic [AW-1:0] per_addr,
  output logic [31:0]   per_wdata,
  output logic [3:0]    per_strb,
  input  logic [31:0]   per_rdata,
  input  logic          per_ready,
  input  logic          per_err
);
  logic          rst_n_int;
  kind_e         kind;
  logic [31:0]   shaped;
  logic [3:0]    strb;
  logic          reject;
  logic [AW-1:0] addr_al;

  assign addr_al = {req_addr[AW-1:2], 2'b00};

  bridge_rst_sync u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_sync(rst_n_int)
  );

  bridge_win_decode #(
    .AW(AW), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .WIN_KIND(WIN_KIND)
  ) u_dec (
    .addr(req_addr),
    .kind(kind)
  );

  bridge_lane_shaper u_shape (
    .kind  (kind),
    .write (req_write),
    .size  (req_size),
    .off   (req_addr[1:0]),
    .din   (req_wdata),
    .dout  (shaped),
    .strb  (strb),
    .reject(reject)
  );

  bridge_xfer_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_reject (reject),
    .req_addr_al(addr_al),
    .req_data   (shaped),
    .req_strb   (strb),
    .per_ready  (per_ready),
    .per_err    (per_err),
    .per_rdata  (per_rdata),
    .per_sel    (per_sel),
    .per_en     (per_en),
    .per_write  (per_write),
    .per_addr   (per_addr),
    .per_wdata  (per_wdata),
    .per_strb   (per_strb),
    .resp_done  (resp_done),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata)
  );
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          per_sel,
  input logic          per_en,
  input logic          per_write,
  input logic [AW-1:0] per_addr,
  input logic [3:0]    per_strb,
  input logic          per_ready,
  input logic          resp_done,
  input logic          resp_err
);
  p_setup_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_sel && !per_en |=> per_sel && per_en);

  p_access_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_sel && per_en && !per_ready |=> per_sel && per_en && $stable(per_addr) && $stable(per_strb));

  p_done_after_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_sel && per_en && per_ready |=> resp_done && !per_sel);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  p_aligned_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    per_sel |-> per_addr[1:0] == 2'b00);

  p_read_no_strb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    per_sel && !per_write |-> per_strb == 4'b0000);

  p_write_has_strb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    per_sel && per_write |-> per_strb != 4'b0000);

  p_refuse_no_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done && !$past(per_sel) |-> resp_err);
endmodule

bind lane_repl_bridge bridge_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .per_sel  (per_sel),
  .per_en   (per_en),
  .per_write(per_write),
  .per_addr (per_addr),
  .per_strb (per_strb),
  .per_ready(per_ready),
  .resp_done(resp_done),
  .resp_err (resp_err)
);

// File: tb/sim_lane_repl_bridge.sv
`timescale 1ns/1ps
module sim_lane_repl_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        resp_done, resp_err;
  logic [31:0] resp_rdata;
  logic        per_sel, per_en, per_write;
  logic [15:0] per_addr;
  logic [31:0] per_wdata;
  logic [3:0]  per_strb;
  logic [31:0] per_rdata;
  logic        per_ready, per_err;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  lane_repl_bridge u0 (.*);

  logic [31:0] pmem [4][4];
  int          wait_cfg = 0;
  int          wcnt = 0;
  int          xfer_cnt = 0;
  logic [15:0] cap_addr;
  logic [31:0] cap_wdata;
  logic [3:0]  cap_strb;
  logic [31:0] g_rd;
  logic        g_er;
  int          g_lat;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // peripheral model: responds at the falling edge with programmable waits
  initial begin
    per_ready = 1'b0; per_err = 1'b0; per_rdata = '0;
    for (int w = 0; w < 4; w++) for (int k = 0; k < 4; k++) pmem[w][k] = '0;
    forever begin
      @(negedge clk);
      per_ready = 1'b0;
      per_err   = 1'b0;
      if (per_sel && per_en) begin
        if (wcnt == wait_cfg) begin
          wcnt = 0;
          per_ready = 1'b1;
          xfer_cnt++;
          cap_addr = per_addr; cap_wdata = per_wdata; cap_strb = per_strb;
          if (per_write) begin
            for (int b = 0; b < 4; b++)
              if (per_strb[b]) pmem[per_addr[13:12]][per_addr[3:2]][8*b +: 8] = per_wdata[8*b +: 8];
          end else begin
            per_rdata = pmem[per_addr[13:12]][per_addr[3:2]];
          end
          per_err = (per_addr == 16'h100C);
        end else begin
          wcnt++;
        end
      end
    end
  end

  // one request, with the expected bus phase compared on every clock
  task automatic txn(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input int wt);
    logic ph_bad;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    wait_cfg = wt; g_lat = 0; ph_bad = 1'b0;
    forever begin
      @(negedge clk);
      g_lat++;
      if (resp_done) break;
      if (g_lat == 1) begin
        if (!(per_sel && !per_en)) ph_bad = 1'b1;
      end else if (!(per_sel && per_en)) ph_bad = 1'b1;
    end
    g_rd = resp_rdata; g_er = resp_err;
    req_valid = 1'b0;
    chk("R7 phase sequence", 32'(ph_bad), 32'd0);
  endtask

  initial begin
    #1_000_000;
    tests++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset sel/en/done", {29'd0, per_sel, per_en, resp_done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 / R7: lane window word write, no waits
    txn(1'b1, 16'h0004, 2'b10, 32'h11223344, 0);
    chk("R11 word strobes", 32'(cap_strb), 32'hF);
    chk("R11 word data", cap_wdata, 32'h11223344);
    chk("R7 latency no wait", g_lat, 3);
    txn(1'b0, 16'h0004, 2'b10, 32'h0, 0);
    chk("R9 word readback", g_rd, 32'h11223344);

    // R4: byte at offset 1
    txn(1'b1, 16'h0005, 2'b00, 32'h000000AB, 0);
    chk("R4 byte strobe off1", 32'(cap_strb), 32'h2);
    txn(1'b0, 16'h0004, 2'b10, 32'h0, 0);
    chk("R4 byte lane only", g_rd, 32'h1122AB44);

    // R4 / R7: half at offset 2 with two wait states
    txn(1'b1, 16'h0006, 2'b01, 32'h0000BEEF, 2);
    chk("R4 half strobe off2", 32'(cap_strb), 32'hC);
    chk("R7 latency two waits", g_lat, 5);

    // R4: byte at offset 0 with junk above the byte
    txn(1'b1, 16'h0004, 2'b00, 32'hFFFFFF77, 0);
    chk("R4 byte strobe off0", 32'(cap_strb), 32'h1);

    // R9: narrow read returns whole word, aligned, no strobes
    txn(1'b0, 16'h0007, 2'b00, 32'h0, 1);
    chk("R9 byte read full word", g_rd, 32'hBEEFAB77);
    chk("R9 read aligned addr", 32'(cap_addr), 32'h0004);
    chk("R9 read strobes zero", 32'(cap_strb), 32'h0);

    // R1: lenient window byte at offset 3
    txn(1'b1, 16'h2003, 2'b00, 32'h0000005A, 0);
    chk("R1 repl byte addr", 32'(cap_addr), 32'h2000);
    chk("R1 repl byte data", cap_wdata, 32'h5A5A5A5A);
    chk("R1 repl byte strobes", 32'(cap_strb), 32'hF);
    txn(1'b0, 16'h2001, 2'b00, 32'h0, 0);
    chk("R1 repl all lanes changed", g_rd, 32'h5A5A5A5A);

    // R2: lenient window half at offset 2
    txn(1'b1, 16'h2006, 2'b01, 32'h00001234, 0);
    chk("R2 repl half addr", 32'(cap_addr), 32'h2004);
    chk("R2 repl half data", cap_wdata, 32'h12341234);
    chk("R2 repl half strobes", 32'(cap_strb), 32'hF);

    // R3: strict window narrow write and narrow read
    n0 = xfer_cnt;
    txn(1'b1, 16'h1001, 2'b00, 32'h000000EE, 0);
    chk("R3 strict byte err", 32'(g_er), 32'd1);
    chk("R3 strict byte latency", g_lat, 1);
    txn(1'b0, 16'h1002, 2'b01, 32'h0, 0);
    chk("R3 strict half read err", 32'(g_er), 32'd1);
    chk("R3 no downstream xfer", xfer_cnt - n0, 0);

    // R11: strict window word write allowed
    txn(1'b1, 16'h1008, 2'b10, 32'hCAFEF00D, 0);
    chk("R11 strict word ok", 32'(g_er), 32'd0);
    chk("R11 strict word data", pmem[1][2], 32'hCAFEF00D);

    // R5: illegal size
    n0 = xfer_cnt;
    txn(1'b1, 16'h0000, 2'b11, 32'h12345678, 0);
    chk("R5 illegal size err", 32'(g_er), 32'd1);
    chk("R5 no downstream xfer", xfer_cnt - n0, 0);

    // R6: misaligned half in lane window and word in lenient window
    txn(1'b1, 16'h0001, 2'b01, 32'h00005555, 0);
    chk("R6 odd half err", 32'(g_er), 32'd1);
    txn(1'b1, 16'h2002, 2'b10, 32'h99999999, 0);
    chk("R6 unaligned word err", 32'(g_er), 32'd1);
    chk("R6 no downstream xfer", xfer_cnt - n0, 0);
    chk("R6 target untouched", pmem[2][0], 32'h5A5A5A5A);

    // R8: peripheral error forwarded
    txn(1'b0, 16'h100C, 2'b10, 32'h0, 0);
    chk("R8 peripheral err forwarded", 32'(g_er), 32'd1);
    chk("R8 latency full transfer", g_lat, 3);
    txn(1'b0, 16'h1008, 2'b10, 32'h0, 0);
    chk("R8 clean after err", 32'(g_er), 32'd0);
    chk("R9 strict word read", g_rd, 32'hCAFEF00D);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule